// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block loads one four-word transfer descriptor from memory for a single DMA channel. The channel control pulses a fetch command and presents the channel's current next-descriptor pointer together with the channel's compare-status flag. The sequencer then works out where the descriptor lives. The base is the pointer with its low four bits cleared. If the pointer's branch-enable bit is set and the compare flag is set, an alternate descriptor 32 bytes further on is used instead. The sequencer then reads the four words one at a time through a simple 32-bit read master.

The words arrive as next-descriptor pointer, source address, target address and command. They are captured into the channel's registers. When the command word names a flow-controlled source or target, the matching address is forced to word alignment. One cycle after the last word is captured, a single-cycle done pulse is raised. Alongside it come an optional start event and an error flag for command modes the transfer engine cannot perform. The read port holds its request and address until data returns, so memory may insert any number of wait states.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, rd_req, busy, done, start_evt and bad_mode are 0, and next_ptr, src_addr, dst_addr and cmd_word are 0.
- R2: The first read address equals ptr_in with bits 3:0 cleared, plus 32 when ptr_in bit 1 and cmp_flag are both 1 at the fetch command; otherwise nothing is added.
- R3: A fetch issues exactly four reads at base, base+4, base+8 and base+12, in that order. rd_req and rd_addr stay unchanged while rd_valid is low.
- R4: The words returned are stored in order into next_ptr, src_addr, dst_addr and cmd_word. next_ptr keeps every bit as read, including bit 0, the stop marker.
- R5: When bit 29 of the command word is 1, src_addr bits 1:0 read as 0. When bit 28 is 1, dst_addr bits 1:0 read as 0. Otherwise these bits are kept as read.
- R6: done is high for exactly one cycle, in the second cycle after the edge that captures the fourth word. busy is high from the cycle after the accepted fetch command until done rises.
- R7: start_evt is high together with done when bit 22 of the command word is 1, and is low at all other times.
- R8: bad_mode is high together with done when any of command bits 25, 20 or 19 is 1, and is low at all other times.
- R9: A fetch command while busy is 1 is ignored: no extra read is issued and the running sequence is unchanged.
- R10: rd_valid while rd_req is 0 changes no descriptor register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_start | input | 1 | Fetch command from channel control |
| ptr_in | input | 32 | Current next-descriptor pointer |
| cmp_flag | input | 1 | Channel compare-status flag |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | 32 | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Fetch sequence in progress |
| next_ptr | output | 32 | Loaded next-descriptor pointer |
| src_addr | output | 32 | Loaded source address |
| dst_addr | output | 32 | Loaded target address |
| cmd_word | output | 32 | Loaded command word |
| done | output | 1 | One-cycle fetch-complete pulse |
| start_evt | output | 1 | Start event, with done |
| bad_mode | output | 1 | Unsupported command mode seen, with done |

## Verification
The hardest case to reach from the ports is a fetch command that arrives in the one cycle after the last word has been captured. At that point the sequencer is still busy but no longer reading. Because the memory model inserts a random number of wait states, this cycle does not line up with any fixed count. The bench therefore tracks captures itself and pulses fetch_start exactly in that cycle, as well as in the middle of the reads. It then checks that no fifth read and no second sequence follow. Directed fetches cover each combination of the branch bit and the compare flag, and each alignment bit and event bit of the command word.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_READ, SQ_FIN} sq_state_t;

  localparam int DESC_WORDS        = 4;
  localparam int PTR_BRANCH_BIT    = 1;
  localparam int CMD_FLOW_SRC_BIT  = 29;
  localparam int CMD_FLOW_DST_BIT  = 28;
  localparam int CMD_CMP_BIT       = 25;
  localparam int CMD_START_IRQ_BIT = 22;
  localparam int CMD_FLY_SRC_BIT   = 20;
  localparam int CMD_FLY_DST_BIT   = 19;
endpackage

// File: rtl/desc_base_calc.sv
module desc_base_calc #(
  parameter int AW         = 32,
  parameter int ALIGN_BITS = 4,
  parameter int BRANCH_OFS = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic          cmp_flag,
  output logic [AW-1:0] base
);
  import dma_desc_pkg::*;

  logic [AW-1:0] aligned;

  always_comb begin
    aligned = {ptr[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    // R2: branch to the alternate descriptor when enabled and compare set
    if (ptr[PTR_BRANCH_BIT] && cmp_flag)
      base = aligned + AW'(BRANCH_OFS);
    else
      base = aligned;
  end
endmodule

// File: rtl/desc_seq_fsm.sv
module desc_seq_fsm #(
  parameter int AW     = 32,
  parameter int NWORDS = 4,
  parameter int STEP   = 4,
  localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_start,
  input  logic [AW-1:0] base,
  input  logic          rd_valid,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          word_we,
  output logic [IW-1:0] word_idx,
  output logic          seq_end
);
  import dma_desc_pkg::*;

  sq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      word_idx <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          // R9: commands are only taken here
          if (fetch_start) begin
            state    <= SQ_READ;
            rd_req   <= 1'b1;
            rd_addr  <= base;
            word_idx <= '0;
          end
        end
        SQ_READ: begin
          if (rd_valid) begin
            if (word_idx == IW'(NWORDS-1)) begin
              state  <= SQ_FIN;
              rd_req <= 1'b0;
            end else begin
              word_idx <= word_idx + 1'b1;
              rd_addr  <= rd_addr + AW'(STEP);
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state != SQ_IDLE);
  assign word_we = (state == SQ_READ) && rd_valid;   // R10
  assign seq_end = (state == SQ_FIN);
endmodule

// File: rtl/desc_word_regs.sv
module desc_word_regs #(
  parameter int DW     = 32,
  parameter int NWORDS = 4,
  localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_we,
  input  logic [IW-1:0] word_idx,
  input  logic [DW-1:0] rd_data,
  input  logic          seq_end,
  output logic [DW-1:0] next_ptr,
  output logic [DW-1:0] src_addr,
  output logic [DW-1:0] dst_addr,
  output logic [DW-1:0] cmd_word,
  output logic          done,
  output logic          start_evt,
  output logic          bad_mode
);
  import dma_desc_pkg::*;

  logic [DW-1:0] wq [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) wq[i] <= '0;
    end else if (word_we) begin
      wq[word_idx] <= rd_data;
      // R5: the command word arrives last and aligns flow-controlled addresses
      if (word_idx == IW'(NWORDS-1)) begin
        if (rd_data[CMD_FLOW_SRC_BIT]) wq[1][1:0] <= 2'b00;
        if (rd_data[CMD_FLOW_DST_BIT]) wq[2][1:0] <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      start_evt <= 1'b0;
      bad_mode  <= 1'b0;
    end else begin
      done      <= seq_end;
      start_evt <= seq_end && wq[3][CMD_START_IRQ_BIT];
      bad_mode  <= seq_end && (wq[3][CMD_CMP_BIT] || wq[3][CMD_FLY_SRC_BIT]
                               || wq[3][CMD_FLY_DST_BIT]);
    end
  end

  assign next_ptr = wq[0];
  assign src_addr = wq[1];
  assign dst_addr = wq[2];
  assign cmd_word = wq[3];
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_start,
  input  logic [AW-1:0] ptr_in,
  input  logic          cmp_flag,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [DW-1:0] next_ptr,
  output logic [DW-1:0] src_addr,
  output logic [DW-1:0] dst_addr,
  output logic [DW-1:0] cmd_word,
  output logic          done,
  output logic          start_evt,
  output logic          bad_mode
);
  import dma_desc_pkg::*;

  localparam int NW   = DESC_WORDS;
  localparam int IW   = $clog2(NW);
  localparam int STEP = DW / 8;

  logic [AW-1:0] base;
  logic          word_we;
  logic [IW-1:0] word_idx;
  logic          seq_end;

  desc_base_calc #(.AW(AW), .ALIGN_BITS(4), .BRANCH_OFS(32)) u_base (
    .ptr(ptr_in), .cmp_flag(cmp_flag), .base(base)
  );

  desc_seq_fsm #(.AW(AW), .NWORDS(NW), .STEP(STEP)) u_fsm (
    .clk(clk), .rst(rst), .fetch_start(fetch_start), .base(base),
    .rd_valid(rd_valid), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
    .word_we(word_we), .word_idx(word_idx), .seq_end(seq_end)
  );

  desc_word_regs #(.DW(DW), .NWORDS(NW)) u_regs (
    .clk(clk), .rst(rst), .word_we(word_we), .word_idx(word_idx),
    .rd_data(rd_data), .seq_end(seq_end), .next_ptr(next_ptr),
    .src_addr(src_addr), .dst_addr(dst_addr), .cmd_word(cmd_word),
    .done(done), .start_evt(start_evt), .bad_mode(bad_mode)
  );
endmodule

// File: rtl/dma_desc_loader_chk.sv
module dma_desc_loader_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_start,
  input logic [AW-1:0] ptr_in,
  input logic          cmp_flag,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          busy,
  input logic [DW-1:0] next_ptr,
  input logic [DW-1:0] src_addr,
  input logic [DW-1:0] dst_addr,
  input logic [DW-1:0] cmd_word,
  input logic          done,
  input logic          start_evt,
  input logic          bad_mode
);
  a_r3_hold_until_valid: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_valid |=> !rd_req || (rd_addr == $past(rd_addr) + AW'(DW/8)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  a_r7_start_with_done: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> done);

  a_r8_bad_with_done: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> done);

  a_r5_src_aligned: assert property (@(posedge clk) disable iff (rst)
    done && cmd_word[29] |-> src_addr[1:0] == 2'b00);

  a_r5_dst_aligned: assert property (@(posedge clk) disable iff (rst)
    done && cmd_word[28] |-> dst_addr[1:0] == 2'b00);

  a_r10_idle_regs_stable: assert property (@(posedge clk) disable iff (rst)
    !busy && !fetch_start |=> $stable(next_ptr) && $stable(cmd_word));
endmodule

bind dma_desc_loader dma_desc_loader_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_dma_desc_loader.sv
module tb_dma_desc_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_start;
  logic [31:0] ptr_in;
  logic        cmp_flag;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        busy;
  logic [31:0] next_ptr, src_addr, dst_addr, cmd_word;
  logic        done, start_evt, bad_mode;

  int total = 0;
  int bad = 0;
  logic [31:0] cmd_pat;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_loader dut (
    .clk(clk), .rst(rst), .fetch_start(fetch_start), .ptr_in(ptr_in),
    .cmp_flag(cmp_flag), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .next_ptr(next_ptr), .src_addr(src_addr), .dst_addr(dst_addr),
    .cmd_word(cmd_word), .done(done), .start_evt(start_evt),
    .bad_mode(bad_mode)
  );

  function automatic logic [31:0] memdata(logic [31:0] a);
    if (a[3:2] == 2'd3) return cmd_pat;
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ (a >> 7);
  endfunction

  function automatic logic [31:0] exp_base(logic [31:0] p, logic c);
    logic [31:0] b;
    b = {p[31:4], 4'h0};
    if (p[1] && c) b = b + 32'd32;
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] p, input logic c,
                          input logic [31:0] cmd, input int max_wait,
                          input bit inject);
    logic [31:0] b, w0, w1, w2;
    int k, wt, guard;
    bit done_early;
    cmd_pat = cmd;
    b = exp_base(p, c);
    w0 = memdata(b); w1 = memdata(b + 4); w2 = memdata(b + 8);
    if (cmd[29]) w1[1:0] = 2'b00;
    if (cmd[28]) w2[1:0] = 2'b00;
    @(negedge clk);
    ptr_in = p; cmp_flag = c; fetch_start = 1'b1;
    k = 0; wt = $urandom % (max_wait + 1); guard = 0; done_early = 0;
    while (k < 4 && guard < 200) begin
      @(negedge clk);
      guard++;
      fetch_start = 1'b0; rd_valid = 1'b0;
      ptr_in = $urandom; cmp_flag = $urandom;
      if (done) done_early = 1;
      if (inject && k == 1) fetch_start = 1'b1;          // R9 mid-sequence
      if (rd_req) begin
        if (wt > 0) wt--;
        else begin
          chk(rd_addr == b + 32'(4*k), (k == 0) ? "R2" : "R3", "read address",
              rd_addr, b + 32'(4*k));
          rd_valid = 1'b1; rd_data = memdata(rd_addr);
          k++;
          wt = $urandom % (max_wait + 1);
        end
      end
    end
    chk(k == 4 && !done_early, "R3", "four reads without early done", k, 4);
    @(negedge clk);  // fourth word captured, state is finishing
    rd_valid = 1'b0; rd_data = $urandom;
    chk(!done && busy && !rd_req, "R6", "no done yet, still busy",
        {done, busy, rd_req}, 3'b010);
    if (inject) fetch_start = 1'b1;                      // R9 final busy cycle
    @(negedge clk);
    fetch_start = 1'b0;
    chk(done && !busy, "R6", "done pulse", {done, busy}, 2'b10);
    chk(next_ptr == w0, "R4", "next_ptr", next_ptr, w0);
    chk(src_addr == w1, "R5", "src_addr", src_addr, w1);
    chk(dst_addr == w2, "R5", "dst_addr", dst_addr, w2);
    chk(cmd_word == cmd, "R4", "cmd_word", cmd_word, cmd);
    chk(start_evt == cmd[22], "R7", "start_evt", start_evt, cmd[22]);
    chk(bad_mode == (cmd[25] | cmd[20] | cmd[19]), "R8", "bad_mode",
        bad_mode, cmd[25] | cmd[20] | cmd[19]);
    @(negedge clk);
    chk(!done && !start_evt && !bad_mode, "R6", "pulse ends",
        {done, start_evt, bad_mode}, 0);
    chk(!rd_req && !busy, "R9", "busy fetch ignored", {rd_req, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'd20240611));
    rst = 1'b1; fetch_start = 0; ptr_in = 0; cmp_flag = 0;
    rd_valid = 0; rd_data = 0; cmd_pat = 0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !busy && !done && !start_evt && !bad_mode, "R1",
        "reset controls", {rd_req, busy, done, start_evt, bad_mode}, 0);
    chk(next_ptr == 0 && src_addr == 0 && dst_addr == 0 && cmd_word == 0,
        "R1", "reset regs", next_ptr | src_addr | dst_addr | cmd_word, 0);
    rst = 1'b0;
    // R2 branch combinations
    do_fetch(32'h0000_1003, 1'b1, 32'h0000_0010, 0, 0);
    do_fetch(32'h0000_1003, 1'b0, 32'h0000_0010, 2, 0);
    do_fetch(32'h0000_2001, 1'b1, 32'h0000_0010, 1, 0);
    do_fetch(32'hFFFF_FFFE, 1'b1, 32'h0000_0000, 3, 0);
    // R5 alignment, R7 start event, R8 unsupported modes
    do_fetch(32'h0000_3000, 1'b0, 32'h3040_0000, 2, 0);
    do_fetch(32'h0000_3040, 1'b0, 32'h1000_0000, 0, 0);
    do_fetch(32'h0000_3080, 1'b0, 32'h0200_0000, 1, 0);
    do_fetch(32'h0000_30C0, 1'b0, 32'h0010_0000, 1, 0);
    do_fetch(32'h0000_3100, 1'b0, 32'h0008_0000, 0, 0);
    // R9 fetch commands while busy
    do_fetch(32'h0000_4002, 1'b1, 32'h0040_0000, 3, 1);
    do_fetch(32'h0000_5000, 1'b0, $urandom, 0, 1);
    // R10 stray valid while idle
    snap = next_ptr;
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    chk(next_ptr == snap && !busy, "R10", "stray valid ignored", next_ptr, snap);
    // random mix
    for (int i = 0; i < 40; i++)
      do_fetch($urandom, 1'($urandom), $urandom, 3, 1'($urandom % 4 == 0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule